// File: doc/BRIEF.md
# Timing Error Collection and Sampling Tree

This block gathers the error indications of every error-detecting latch in one pipeline stage and reduces them to a single dual-rail verdict for the stage controller. Each latch position has a behavioural detector. While the stage's latch enable is high and the resiliency window is still open, the detector compares the data bit with its value at the previous clock edge. Any difference sets a sticky error flag. The flags are grouped three at a time into asymmetric C-element cells, and the enable acts as the fourth input of each cell. Four such cells feed an OR tree. The result goes into a dual-rail sampler, so one sampler serves twelve latch positions.

The stage controller raises the sample strobe at the end of the resiliency window, and the detectors stop flagging from that point. The sampler spends one deterministic resolution cycle before it drives exactly one rail: `err1` reports a timing error and `err0` reports clean data. Because exactly one rail is driven, a nonzero rail pair is itself the valid indication. When there are several samplers, their rails are merged into one verdict for the stage. Lowering the latch enable clears the stored error state, which makes the tree ready for the next cycle.

Top module: `timing_err_tree`

## Requirements
- R1: During reset and immediately after it, both rails are low and no error is stored. A sample with no data change then reports clean (`err0`=1, `err1`=0).
- R2: If any data bit differs from its value at the previous clock edge, at an edge where `lat_en`=1 and `sample`=0, the next verdict has `err1`=1 and `err0`=0.
- R3: If no data bit changes while the window is open, the verdict has `err0`=1 and `err1`=0.
- R4: A data change at an edge where `lat_en`=0 is not flagged.
- R5: A data change at an edge where `sample`=1 (window closed) is not flagged.
- R6: The rails stay low at the first rising edge that sees `sample`=1. The verdict appears at the second such edge and is held unchanged while `sample` stays high.
- R7: Both rails go low at the first rising edge that sees `sample`=0. The two rails are never high together.
- R8: The detector flags clear at the first edge where `lat_en`=0. An error in one window therefore does not affect the next window.
- R9: A group cell sets while `lat_en` is high and any of its three flags is set. It keeps its state while `lat_en` is high. It clears only when `lat_en` is low and all three of its flags are low.
- R10: With several samplers, `err1` is the OR of the sampler error rails, and `err0` is high only when every sampler reports clean. Latch bit i belongs to sampler i/12.
- R11: Several changes in one window, on one bit (including a change back to the original value) or on several bits, still give a single `err1` verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_d | input | NUM_BITS | Data inputs of the monitored latches |
| lat_en | input | 1 | Latch enable; opens the window while high |
| sample | input | 1 | Sample strobe marking the end of the resiliency window |
| err1 | output | 1 | Error rail of the stage verdict |
| err0 | output | 1 | Clean rail of the stage verdict |

## Verification
The bench builds the tree with NUM_BITS=24, which gives two samplers and eight group cells. With that size the rail merge across samplers can be tested: an error confined to the upper sampler must still raise `err1` and suppress `err0`. Directed windows place changes before the window opens, inside it, and on the closing strobe. Random windows then mix in-window and late changes on random bits and compare the verdict with an OR of the in-window changes.

// File: rtl/tet_pkg.sv
// Package: shared constants of the timing error tree.
// Assumes: the group and sampler fan-in are fixed by the cell library.
package tet_pkg;
    localparam int EDL_PER_GROUP      = 3;
    localparam int GROUPS_PER_SAMPLER = 4;
    localparam int EDL_PER_SAMPLER    = EDL_PER_GROUP * GROUPS_PER_SAMPLER;
endpackage

// File: rtl/tet_edl_bank.sv
// Module: bank of behavioural error-detecting latches.
// Each bit raises a sticky flag when its data differs from the value seen at
// the previous edge while lat_en is high and sample is low.
// Flags clear whenever lat_en is low.
// Assumes: lat_d is driven synchronously to clk.
module tet_edl_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lat_d,
    input  logic         lat_en,
    input  logic         sample,
    output logic [N-1:0] flags
);
    logic [N-1:0] d_q;

    // Record the data of the previous edge and update the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q   <= '0;
            flags <= '0;
        end else begin
            d_q <= lat_d;
            if (!lat_en)
                flags <= '0;
            else if (!sample)
                flags <= flags | (lat_d ^ d_q);
        end
    end

    // R8: flags are empty one edge after lat_en is seen low
    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_en |=> (flags == '0));
    // R2: a flag, once set, stays set while the enable is high
    assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lat_en |=> ((flags & $past(flags)) == $past(flags)));
    // R5: no new flag appears while sample is high
    assert_no_late_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_en && sample) |=> (flags == $past(flags)));
endmodule

// File: rtl/tet_cgroup.sv
// Module: asymmetric C-element merging three detector flags.
// The output sets when the enable and any flag are high.
// It clears only when the enable and all flags agree low; otherwise it holds.
// Assumes: flags clear one edge after the enable falls.
module tet_cgroup #(
    parameter int W = tet_pkg::EDL_PER_GROUP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] flags,
    output logic         grp
);
    // Set on enable with an error, clear on full agreement low, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp <= 1'b0;
        else if (en && (|flags))
            grp <= 1'b1;
        else if (!en && !(|flags))
            grp <= 1'b0;
    end

    // R9: held while the enable is high
    assert_grp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && grp) |=> grp);
    // R9: cleared once the enable and flags are all low
    assert_grp_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(|flags)) |=> !grp);
endmodule

// File: rtl/tet_sampler.sv
// Module: one sampler covering EDL_PER_SAMPLER detectors.
// Groups the flags into C-element cells and ORs the cells. One edge after
// the strobe is seen high, it captures a dual-rail verdict. The rails drop
// when the strobe is seen low.
// Assumes: lat_en stays high until the strobe has been seen high.
module tet_sampler
    import tet_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lat_en,
    input  logic                       sample,
    input  logic [EDL_PER_SAMPLER-1:0] flags,
    output logic                       err1,
    output logic                       err0
);
    logic [GROUPS_PER_SAMPLER-1:0] grp;
    logic                          any_err;
    logic                          samp_q;

    for (genvar g = 0; g < GROUPS_PER_SAMPLER; g++) begin : g_cell
        tet_cgroup #(.W(EDL_PER_GROUP)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (lat_en),
            .flags (flags[g*EDL_PER_GROUP +: EDL_PER_GROUP]),
            .grp   (grp[g])
        );
    end

    // OR tree over the group cells.
    assign any_err = |grp;

    // Resolution stage, then a one-hot capture of the rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            err1   <= 1'b0;
            err0   <= 1'b0;
        end else begin
            samp_q <= sample;
            if (!sample) begin
                err1 <= 1'b0;
                err0 <= 1'b0;
            end else if (samp_q && !err1 && !err0) begin
                err1 <= any_err;
                err0 <= !any_err;
            end
        end
    end

    // R7: never both rails
    assert_rails_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err1 && err0));
    // R7: rails return low after the strobe falls
    assert_rails_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> (!err1 && !err0));
    // R6: verdict held while the strobe stays high
    assert_rails_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && (err1 || err0)) |=> $stable({err1, err0}));
    // R6: no verdict on the first edge that sees the strobe
    assert_rails_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !samp_q) |=> (!err1 && !err0));
endmodule

// File: rtl/timing_err_tree.sv
// Module: top of the timing error collection tree for one pipeline stage.
// It instantiates the detector bank and one sampler per twelve bits, and
// merges the sampler rails into the stage verdict.
// Assumes: NUM_BITS is a positive multiple of EDL_PER_SAMPLER.
module timing_err_tree
    import tet_pkg::*;
#(
    parameter int NUM_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] lat_d,
    input  logic                lat_en,
    input  logic                sample,
    output logic                err1,
    output logic                err0
);
    localparam int NUM_SAMPLERS = NUM_BITS / EDL_PER_SAMPLER;

    logic [NUM_BITS-1:0]     flags;
    logic [NUM_SAMPLERS-1:0] s_err1;
    logic [NUM_SAMPLERS-1:0] s_err0;

    tet_edl_bank #(.N(NUM_BITS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .lat_d  (lat_d),
        .lat_en (lat_en),
        .sample (sample),
        .flags  (flags)
    );

    for (genvar s = 0; s < NUM_SAMPLERS; s++) begin : g_smp
        tet_sampler u_smp (
            .clk    (clk),
            .rst_n  (rst_n),
            .lat_en (lat_en),
            .sample (sample),
            .flags  (flags[s*EDL_PER_SAMPLER +: EDL_PER_SAMPLER]),
            .err1   (s_err1[s]),
            .err0   (s_err0[s])
        );
    end

    // Stage merge: any error wins, clean only when all samplers are clean.
    assign err1 = |s_err1;
    assign err0 = &s_err0;

    // R10: the stage rails stay mutually exclusive after the merge
    assert_stage_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(err1 && err0));
    // R1: rails are low on the first edge after reset
    assert_reset_rails_R1: assert property (@(posedge clk)
        !rst_n |=> (!err1 && !err0));
endmodule

// File: tb/timing_err_tree_test.sv
module timing_err_tree_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] lat_d = '0;
    logic          lat_en = 1'b0;
    logic          sample = 1'b0;
    logic          err1;
    logic          err0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timing_err_tree #(.NUM_BITS(NB)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .lat_d  (lat_d),
        .lat_en (lat_en),
        .sample (sample),
        .err1   (err1),
        .err0   (err0)
    );

    task automatic check(input logic [1:0] exp, input string req);
        n_checks++;
        if ({err1, err0} !== exp) begin
            n_fail++;
            $display("FAIL %s: rails {err1,err0}=%b expected %b", req, {err1, err0}, exp);
        end
    endtask

    // One full window: pre_m before opening, in_m inside, late_m with the strobe.
    task automatic run_window(input logic [NB-1:0] pre_m, input logic [NB-1:0] in_m,
                              input logic [NB-1:0] in2_m, input logic [NB-1:0] late_m,
                              input string req);
        logic [1:0] exp;
        exp = ((in_m | in2_m) != '0) ? 2'b10 : 2'b01;
        @(negedge clk) lat_d = lat_d ^ pre_m;
        @(negedge clk) lat_en = 1'b1;
        @(negedge clk);
        @(negedge clk) lat_d = lat_d ^ in_m;
        @(negedge clk) lat_d = lat_d ^ in2_m;
        @(negedge clk) begin sample = 1'b1; lat_d = lat_d ^ late_m; end
        @(negedge clk) check(2'b00, {req, " R6 latency"});
        @(negedge clk) check(exp, req);
        @(negedge clk) check(exp, {req, " R6 hold"});
        @(negedge clk) sample = 1'b0;
        @(negedge clk) begin check(2'b00, {req, " R7 drop"}); lat_en = 1'b0; end
        @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk) check(2'b00, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk) check(2'b00, "R1 after reset");
        run_window('0, '0, '0, '0, "R1 clean after reset");
    endtask

    task automatic t_clean;
        run_window('0, '0, '0, '0, "R3 clean window");
    endtask

    task automatic t_single_err;
        run_window('0, NB'(1) << 4, '0, '0, "R2 single bit sampler0");
    endtask

    task automatic t_recover;
        run_window('0, '0, '0, '0, "R8 clean after error");
    endtask

    task automatic t_disabled;
        run_window(NB'(1) << 7, '0, '0, '0, "R4 change while disabled");
    endtask

    task automatic t_late;
        run_window('0, '0, '0, NB'(1) << 2, "R5 change after close");
    endtask

    task automatic t_merge;
        run_window('0, NB'(1) << 17, '0, '0, "R10 error in sampler1 only");
        run_window('0, NB'(1) << 23, '0, NB'(1) << 1, "R10 sampler1 error, late sampler0");
    endtask

    task automatic t_multi;
        run_window('0, NB'(1) << 9, NB'(1) << 9, '0, "R11 toggle and back");
        run_window('0, 24'h000F0F, 24'h800000, '0, "R11 many bits");
        run_window('0, NB'(1) << 11, '0, '0, "R9 group cell holds last bit");
    endtask

    task automatic t_random;
        for (int k = 0; k < 20; k++) begin
            logic [NB-1:0] in_m;
            logic [NB-1:0] late_m;
            in_m = '0;
            late_m = '0;
            if ($urandom_range(0, 1) == 1) in_m[$urandom_range(0, NB-1)] = 1'b1;
            if ($urandom_range(0, 1) == 1) late_m[$urandom_range(0, NB-1)] = 1'b1;
            run_window('0, in_m, '0, late_m, "R2 R5 random window");
        end
    endtask

    initial begin
        t_reset();
        t_clean();
        t_single_err();
        t_recover();
        t_disabled();
        t_late();
        t_merge();
        t_multi();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule